// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the oversampled D+/D- pair of a low-speed USB link into a stream of received bytes. Both lines are first brought into the system clock domain by a chain of flops. On an idle bus (J) the block waits for the first J-to-K change, then hunts through the alternating sync preamble. It accepts the preamble only when two K bit times follow each other. From then on it decodes the NRZI line, drops the bit that follows every run of six ones, and shifts each byte in least significant bit first.

A completed byte is offered for one clock on `byte_valid` together with `byte_data` and a running count, so a plain write-strobe buffer can take it directly. A single-ended zero ends the packet. More bytes than the buffer holds abort the packet. A broken preamble is flagged so the surrounding logic can treat it as a marker or keepalive event. The system clock runs at `OVERSAMPLE` (default 8) times the bit rate. The sampling phase restarts on every J/K transition, so each bit is read close to its centre.

Top module: `usb_ls_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, all pulse outputs go low and `byte_count` and `byte_data` go to zero.
- R2: After the preamble, each line bit decodes as 1 when its level (taken from D-; J = D- high, K = D- low) equals the previous bit's level and as 0 otherwise. Bits fill a byte from bit 0 upward. Each finished byte gives a one-cycle `byte_valid`, with `byte_data` holding the byte and `byte_count` holding its 1-based position in the packet.
- R3: The line bit that follows six decoded 1s in a row is discarded, including when the run crosses a byte boundary.
- R4: SE0 (both lines low) sampled at bit position 1 to 7 of a byte ends the packet with a one-cycle `eop`, and the unfinished byte is dropped. SE0 sampled at bit position 0 is read as a K level, so one trailing dribble bit still ends cleanly.
- R5: With `BUF_DEPTH` bytes already delivered, a further finished byte raises a one-cycle `overflow_err` instead of `byte_valid`. The rest of the packet, up to SE0, is ignored and gives no `eop`. The next packet is received normally.
- R6: During the preamble hunt, two J samples in a row, or an SE0 sample, give a one-cycle `sync_err` and return the block to idle with no byte delivered.
- R7: Payload decoding starts only after two consecutive K samples. A preamble of any length that alternates K and J is accepted once it ends in K K.
- R8: The sampling phase restarts on each J/K transition, so packets whose transitions are each moved early or late by one clock decode exactly as nominal ones do.
- R9: SE0 on the idle bus that is not preceded by a J-to-K transition produces no output pulse.
- R10: At most one of `byte_valid`, `eop`, `overflow_err`, `sync_err` is high in any cycle, and none is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, OVERSAMPLE times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| byte_valid | output | 1 | One-cycle write strobe for a received byte |
| byte_data | output | 8 | Received byte, valid with byte_valid |
| byte_count | output | $clog2(BUF_DEPTH+1) | Position of the latest byte in the current packet |
| eop | output | 1 | One-cycle end-of-packet pulse |
| overflow_err | output | 1 | One-cycle pulse when the buffer limit is exceeded |
| sync_err | output | 1 | One-cycle pulse on a broken preamble |

## Verification
A wrong bit counter or a wrong NRZI reference level shows up as a wrong `byte_data` at the first affected byte, about eight bit times after the fault. A stuffing counter that misses a run shifts every later bit, so all bytes after it come out wrong, or a byte is lost before `eop`. A sampling phase that drifts or does not restart on edges shows up only when edges are moved away from their nominal positions. The jittered packets are there to expose that within one run of identical bits. Faults in the hunt or overflow logic show up as missing or extra pulses, counted per packet.

// File: rtl/usbrx_pkg.sv
// Shared types for the low-speed USB receiver.
// Line symbols are encoded as {D+, D-}.
package usbrx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HUNT,
        RX_DATA,
        RX_DRAIN
    } rx_state_t;
endpackage

// File: rtl/usbrx_insync.sv
// Input synchroniser: passes D+ and D- through STAGES flops each and
// presents them as one line symbol. Assumes the inputs are asynchronous
// to clk. Reset state is the idle J symbol.
module usbrx_insync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dp_in,
    input  logic                dm_in,
    output usbrx_pkg::line_t    line
);
    logic [STAGES-1:0] dp_sr;
    logic [STAGES-1:0] dm_sr;

    // shift both lines through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_sr <= '0;
            dm_sr <= '1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                dp_sr[i] <= dp_sr[i-1];
                dm_sr[i] <= dm_sr[i-1];
            end
            dp_sr[0] <= dp_in;
            dm_sr[0] <= dm_in;
        end
    end

    assign line = usbrx_pkg::line_t'({dp_sr[STAGES-1], dm_sr[STAGES-1]});
endmodule

// File: rtl/usbrx_phase.sv
// Sampling phase tracker: a counter that restarts on every J/K transition
// and raises strobe once per bit time, near the bit centre. It also flags
// a J-to-K transition, which starts the preamble hunt.
// Assumes the line is already synchronised.
module usbrx_phase #(
    parameter int OVERSAMPLE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  usbrx_pkg::line_t line,
    output logic             strobe,
    output logic             k_edge
);
    import usbrx_pkg::*;

    localparam int PW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [PW-1:0] SAMPLE_AT = PW'(OVERSAMPLE / 2 - 1);
    localparam logic [PW-1:0] LAST_PH   = PW'(OVERSAMPLE - 1);

    line_t         line_d;
    logic [PW-1:0] phase;
    logic          now_jk;
    logic          prev_jk;
    logic          toggle;

    // detect a change between the two data levels
    always_comb begin
        now_jk  = (line == LN_J) || (line == LN_K);
        prev_jk = (line_d == LN_J) || (line_d == LN_K);
        toggle  = now_jk && prev_jk && (line != line_d);
    end

    // hold the previous symbol and run the bit-phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_d <= LN_J;
            phase  <= '0;
        end else begin
            line_d <= line;
            if (toggle || phase == LAST_PH) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign strobe = (phase == SAMPLE_AT);
    assign k_edge = toggle && (line == LN_K);
endmodule

// File: rtl/usbrx_deser.sv
// Bit decoder and byte assembler: NRZI decode against the previous level,
// removal of the bit after STUFF_RUN ones, LSb-first shifting, and the
// end-of-packet test that skips bit position 0. It acts only on step.
// init loads the state left by the final K of the preamble.
module usbrx_deser #(
    parameter int STUFF_RUN = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         init,
    input  logic                         step,
    input  logic                         lvl,
    input  logic                         se0,
    output logic                         byte_fire,
    output logic                         end_fire,
    output logic [usbrx_pkg::BYTE_W-1:0] byte_next
);
    import usbrx_pkg::*;

    localparam int RW = $clog2(STUFF_RUN + 1);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);
    localparam logic [RW-1:0] RUN_MAX  = RW'(STUFF_RUN);

    logic              prev_lvl;
    logic [BW-1:0]     nbit;
    logic [RW-1:0]     ones;
    logic [BYTE_W-1:0] shreg;
    logic              dec_bit;
    logic              is_stuff;

    // decode the current sample and decide what it means
    always_comb begin
        dec_bit   = (lvl == prev_lvl);
        is_stuff  = (ones == RUN_MAX);
        end_fire  = step && se0 && (nbit != '0);
        byte_fire = step && !end_fire && !is_stuff && (nbit == LAST_BIT);
        byte_next = {dec_bit, shreg[BYTE_W-1:1]};
    end

    // update level reference, run length and shift register
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            prev_lvl <= 1'b0;
            nbit     <= '0;
            ones     <= '0;
            shreg    <= '0;
        end else if (step && !end_fire) begin
            prev_lvl <= lvl;
            if (is_stuff) begin
                ones <= '0;
            end else begin
                shreg <= byte_next;
                nbit  <= nbit + 1'b1;
                ones  <= dec_bit ? ones + 1'b1 : '0;
            end
        end
    end
endmodule

// File: rtl/usb_ls_rx.sv
// Low-speed USB packet receiver top. Synchronises D+/D-, hunts the sync
// preamble until two K bits in a row, then delivers decoded bytes with a
// one-cycle write strobe. It flags end of packet, buffer overflow and
// preamble errors. Assumes clk runs at OVERSAMPLE times the bit rate.
module usb_ls_rx #(
    parameter int OVERSAMPLE  = 8,
    parameter int BUF_DEPTH   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usb_dp,
    input  logic          usb_dm,
    output logic          byte_valid,
    output logic [7:0]    byte_data,
    output logic [CW-1:0] byte_count,
    output logic          eop,
    output logic          overflow_err,
    output logic          sync_err
);
    import usbrx_pkg::*;

    localparam logic [CW-1:0] CAP = CW'(BUF_DEPTH);

    line_t        line;
    logic         strobe;
    logic         k_edge;
    rx_state_t    state;
    logic         hunt_j;
    logic         is_j;
    logic         line_bad;
    logic         sync_done;
    logic         step;
    logic         byte_fire;
    logic         end_fire;
    logic [7:0]   byte_next;

    usbrx_insync #(.STAGES(SYNC_STAGES)) u_insync (
        .clk   (clk),
        .rst_n (rst_n),
        .dp_in (usb_dp),
        .dm_in (usb_dm),
        .line  (line)
    );

    usbrx_phase #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .line   (line),
        .strobe (strobe),
        .k_edge (k_edge)
    );

    // classify the sample taken during the preamble hunt
    always_comb begin
        is_j      = (line == LN_J);
        line_bad  = (line == LN_SE0) || (line == LN_SE1);
        sync_done = (state == RX_HUNT) && strobe && (line == LN_K) && !hunt_j;
        step      = (state == RX_DATA) && strobe;
    end

    usbrx_deser #(.STUFF_RUN(6)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (sync_done),
        .step      (step),
        .lvl       (line[0]),
        .se0       (line == LN_SE0),
        .byte_fire (byte_fire),
        .end_fire  (end_fire),
        .byte_next (byte_next)
    );

    // packet state machine and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RX_IDLE;
            hunt_j       <= 1'b1;
            byte_valid   <= 1'b0;
            byte_data    <= '0;
            byte_count   <= '0;
            eop          <= 1'b0;
            overflow_err <= 1'b0;
            sync_err     <= 1'b0;
        end else begin
            byte_valid   <= 1'b0;
            eop          <= 1'b0;
            overflow_err <= 1'b0;
            sync_err     <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (k_edge) begin
                        state  <= RX_HUNT;
                        hunt_j <= 1'b1;
                    end
                end
                RX_HUNT: begin
                    if (strobe) begin
                        if (line_bad) begin
                            sync_err <= 1'b1;
                            state    <= RX_IDLE;
                        end else if (sync_done) begin
                            state      <= RX_DATA;
                            byte_count <= '0;
                        end else if (is_j && hunt_j) begin
                            sync_err <= 1'b1;
                            state    <= RX_IDLE;
                        end else begin
                            hunt_j <= is_j;
                        end
                    end
                end
                RX_DATA: begin
                    if (end_fire) begin
                        eop   <= 1'b1;
                        state <= RX_IDLE;
                    end else if (byte_fire) begin
                        if (byte_count == CAP) begin
                            overflow_err <= 1'b1;
                            state        <= RX_DRAIN;
                        end else begin
                            byte_valid <= 1'b1;
                            byte_data  <= byte_next;
                            byte_count <= byte_count + 1'b1;
                        end
                    end
                end
                RX_DRAIN: begin
                    if (line == LN_SE0) begin
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_ls_rx_chk.sv
// Port-level property checker for usb_ls_rx, bound to every instance.
module usb_ls_rx_chk #(
    parameter int BUF_DEPTH = 8,
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_valid,
    input logic          eop,
    input logic          overflow_err,
    input logic          sync_err,
    input logic [CW-1:0] byte_count
);
    // R10
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_valid, eop, overflow_err, sync_err}));

    // R10
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> byte_count == $past(byte_count) + 1'b1);

    // R5
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= CW'(BUF_DEPTH));

    // R5
    overflow_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |-> byte_count == CW'(BUF_DEPTH));

    // R4
    eop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop |=> !eop && !byte_valid);

    // R6
    sync_err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err && !byte_valid);
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_DEPTH(BUF_DEPTH)) u_usb_ls_rx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .eop          (eop),
    .overflow_err (overflow_err),
    .sync_err     (sync_err),
    .byte_count   (byte_count)
);

// File: tb/usb_ls_rx_bench.sv
// Self-checking bench: builds line symbol streams from byte lists and
// compares the received pulses and bytes per packet.
module usb_ls_rx_bench;
    localparam int OS    = 8;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int SK = 0, SJ = 1, SE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dp = 1'b0;
    logic          dm = 1'b1;
    logic          byte_valid;
    logic [7:0]    byte_data;
    logic [CW-1:0] byte_count;
    logic          eop;
    logic          overflow_err;
    logic          sync_err;

    always #2 clk = ~clk;

    usb_ls_rx #(.OVERSAMPLE(OS), .BUF_DEPTH(DEPTH)) u_usb_ls_rx (
        .clk (clk), .rst_n (rst_n), .usb_dp (dp), .usb_dm (dm),
        .byte_valid (byte_valid), .byte_data (byte_data),
        .byte_count (byte_count), .eop (eop),
        .overflow_err (overflow_err), .sync_err (sync_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int m_bytes, m_eop, m_ovf, m_serr, m_clash, m_cnt_bad;
    logic [7:0] got [0:15];
    logic prev_any = 1'b0;
    int q[$];
    int lvl, ones;
    logic [7:0] pk [0:15];

    // monitor: collect output pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (m_bytes < 16) got[m_bytes] = byte_data;
                if (int'(byte_count) != m_bytes + 1) m_cnt_bad++;
                m_bytes++;
            end
            if (eop) m_eop++;
            if (overflow_err) m_ovf++;
            if (sync_err) m_serr++;
            if ((int'(byte_valid) + int'(eop) + int'(overflow_err) + int'(sync_err)) > 1) m_clash++;
            if (prev_any && (byte_valid || eop || overflow_err || sync_err)) m_clash++;
            prev_any = byte_valid || eop || overflow_err || sync_err;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        m_bytes = 0; m_eop = 0; m_ovf = 0; m_serr = 0;
    endtask

    task automatic q_start();
        q.delete();
        q.push_back(SK); q.push_back(SJ); q.push_back(SK); q.push_back(SJ);
        q.push_back(SK); q.push_back(SJ); q.push_back(SK); q.push_back(SK);
        lvl = SK; ones = 0;
    endtask

    task automatic q_bit(input int b);
        if (b == 0) begin lvl = 1 - lvl; ones = 0; end
        else ones++;
        q.push_back(lvl);
        if (ones == 6) begin lvl = 1 - lvl; q.push_back(lvl); ones = 0; end
    endtask

    task automatic q_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) q_bit(int'(b[i]));
    endtask

    task automatic q_eop();
        q.push_back(SE); q.push_back(SE);
        for (int i = 0; i < 5; i++) q.push_back(SJ);
    endtask

    function automatic int off(input int i);
        return ((i * 5) % 3) - 1;
    endfunction

    task automatic play(input bit jit);
        for (int i = 0; i < q.size(); i++) begin
            int len;
            len = jit ? 8 + off(i + 1) - off(i) : 8;
            dp = (q[i] == SK);
            dm = (q[i] == SJ);
            repeat (len) @(negedge clk);
        end
        dp = 1'b0; dm = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic packet(input int n, input bit jit);
        clr(); q_start();
        for (int i = 0; i < n; i++) q_byte(pk[i]);
        q_eop(); play(jit);
    endtask

    task automatic check_bytes(input string tag, input int n);
        chk(tag, m_bytes, n);
        for (int i = 0; i < n && i < 16; i++) chk(tag, int'(got[i]), int'(pk[i]));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R2 actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        m_clash = 0; m_cnt_bad = 0; clr();
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 byte_valid", int'(byte_valid), 0);
        chk("R1 eop", int'(eop), 0);
        chk("R1 overflow_err", int'(overflow_err), 0);
        chk("R1 sync_err", int'(sync_err), 0);
        chk("R1 byte_count", int'(byte_count), 0);
        chk("R1 byte_data", int'(byte_data), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2: every single-byte value
        for (int v = 0; v < 256; v++) begin
            pk[0] = 8'(v);
            packet(1, 1'b0);
            check_bytes("R2 single byte", 1);
            chk("R4 eop after byte", m_eop, 1);
            chk("R2 no error", m_ovf + m_serr, 0);
        end

        // R3: stuffing runs across byte boundaries
        pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'hFF; pk[3] = 8'h00;
        pk[4] = 8'hFC; pk[5] = 8'h3F;
        packet(6, 1'b0);
        check_bytes("R3 stuffed run", 6);
        chk("R3 eop", m_eop, 1);

        // R5 boundary and R8 jitter: full buffer, nominal and moved edges
        for (int pass = 0; pass < 3; pass++) begin
            for (int i = 0; i < DEPTH; i++)
                pk[i] = (pass == 2) ? 8'hFF - 8'(i) : 8'(i * 29 + 3 + pass * 64);
            packet(DEPTH, pass != 0);
            check_bytes(pass == 0 ? "R5 full buffer" : "R8 jittered edges", DEPTH);
            chk("R8 eop", m_eop, 1);
            chk("R5 no overflow at limit", m_ovf, 0);
        end

        // R5: one byte too many
        for (int i = 0; i <= DEPTH; i++) pk[i] = 8'(i * 13 + 1);
        packet(DEPTH + 1, 1'b0);
        check_bytes("R5 overflow bytes", DEPTH);
        chk("R5 overflow pulse", m_ovf, 1);
        chk("R5 no eop after overflow", m_eop, 0);
        pk[0] = 8'h96;
        packet(1, 1'b0);
        check_bytes("R5 recovery", 1);
        chk("R5 recovery eop", m_eop, 1);

        // R4: 0..7 extra bits before SE0 (dribble and cut bytes)
        for (int extra = 0; extra < 8; extra++) begin
            clr(); q_start();
            pk[0] = 8'hA5;
            q_byte(pk[0]);
            for (int b = 0; b < extra; b++) q_bit(b % 2);
            q_eop(); play(1'b0);
            check_bytes("R4 partial dropped", 1);
            chk("R4 eop", m_eop, 1);
        end

        // R6: J J during hunt
        clr(); q.delete();
        q.push_back(SK); q.push_back(SJ); q.push_back(SJ);
        play(1'b0);
        chk("R6 sync_err JJ", m_serr, 1);
        chk("R6 no bytes JJ", m_bytes, 0);

        // R6: SE0 during hunt
        clr(); q.delete();
        q.push_back(SK); q.push_back(SJ); q.push_back(SE); q.push_back(SE);
        play(1'b0);
        chk("R6 sync_err SE0", m_serr, 1);
        chk("R6 no eop SE0", m_eop, 0);

        // R7: alternating preamble without K K
        clr(); q.delete();
        for (int i = 0; i < 10; i++) q.push_back(i % 2 == 0 ? SK : SJ);
        q.push_back(SJ);
        play(1'b0);
        chk("R7 no bytes without KK", m_bytes, 0);
        chk("R7 sync_err without KK", m_serr, 1);

        // R7: longer alternating preamble ending in K K
        clr(); q.delete();
        for (int i = 0; i < 12; i++) q.push_back(i % 2 == 0 ? SK : SJ);
        q.push_back(SK); q.push_back(SK);
        lvl = SK; ones = 0;
        pk[0] = 8'h4C;
        q_byte(pk[0]);
        q_eop(); play(1'b0);
        check_bytes("R7 long preamble", 1);
        chk("R7 long preamble no error", m_serr, 0);

        // R9: keepalive SE0 on idle bus
        clr(); q.delete();
        q.push_back(SE); q.push_back(SE); q.push_back(SJ);
        play(1'b0);
        chk("R9 idle SE0 pulses", m_bytes + m_eop + m_ovf + m_serr, 0);

        // R10 and R2: pulse shape and numbering over the whole run
        chk("R10 pulse clash", m_clash, 0);
        chk("R2 byte_count numbering", m_cnt_bad, 0);

        summary();
        $finish;
    end
endmodule